// File: doc/BRIEF.md
# Bus Read-Data Source Selector

This block picks the word a peripheral places on its bus data lines during a read. Three select strobes, produced by an address decoder elsewhere, choose between the received formatter data word, a readback of the narrow control register, and a packed status byte built from four controller status bits and four formatter status bits. All data is carried active-low. Any bit position that the chosen source does not define is driven to the inactive (high) level.

The word is split into a lower and an upper half. The lower half goes through a four-way choice steered by the status and control strobes. The upper half goes through a two-way choice between the received data and the inactive fill. A third strobe narrows a data read to the lower half only. If more than one strobe is high, the select is illegal: the output is forced to all-inactive and an error flag is raised.

With the default option, the selected word and the error flag are captured into an output register on a load enable. That register holds between loads, so results can be checked cycle by cycle.

Top module: `bus_rdsrc_sel`

## Requirements
- R1: A load with all three strobes low presents the full 16-bit received data word on the output, unchanged and without inversion.
- R2: A load with only the control strobe high puts the 6-bit control value on output bits 5..0 and drives bits 15..6 high.
- R3: A load with only the status strobe high puts the controller status on output bits 3..0 (bit 0 write done, bit 1 read done, bit 2 read error, bit 3 parity/data status) and the formatter status on bits 7..4 (bit 4 data end, bit 5 drive ready, bit 6 status one, bit 7 status two). Bits 15..8 are driven high.
- R4: A load with only the half strobe high puts bits 7..0 of the received data on output bits 7..0 and drives bits 15..8 high.
- R5: After reset the output is all high and the error flag is low.
- R6: A load with two or more strobes high drives the output all high and sets the error flag.
- R7: A load with a legal select, meaning at most one strobe high, clears the error flag.
- R8: While the load enable is low, the output and the error flag keep their values, whatever the strobes and the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the selected word into the output register |
| sel_stat_i | input | 1 | Status strobe (first select line) |
| sel_ctrl_i | input | 1 | Control readback strobe (second select line) |
| sel_half_i | input | 1 | Lower-half data strobe (third select line) |
| in_data_ni | input | 16 | Received formatter data word, active low |
| ctrl_ni | input | 6 | Control register value, active low |
| ctl_stat_ni | input | 4 | Controller status bits, active low |
| fmt_stat_ni | input | 4 | Formatter status bits, active low |
| rd_data_no | output | 16 | Selected read word, active low |
| sel_err_o | output | 1 | Illegal select seen on the last load |

## Verification
The hardest case to reach is the interaction between the error flag and the hold behaviour. The flag must survive idle cycles after an illegal load and clear only on the next legal load, while the data inputs move underneath. The stimulus therefore loads every illegal strobe pair and the all-high triple with non-trivial data present. Between loads it changes the strobes and the data with the load enable low, and then follows with a legal load. Distinct bit patterns in each source make any misplaced lane, any inversion and any missing fill show up in the output word.

// File: rtl/bus_rdsrc_pkg.sv
package bus_rdsrc_pkg;

   // Lower-lane source code, indexed by {control strobe, status strobe}
   typedef enum logic [1:0] {
      LO_DATA = 2'b00,
      LO_STAT = 2'b01,
      LO_CTRL = 2'b10,
      LO_IDLE = 2'b11
   } lo_src_e;

   // Upper-lane source code
   typedef enum logic {
      HI_DATA = 1'b0,
      HI_FILL = 1'b1
   } hi_src_e;

   typedef struct packed {
      lo_src_e lo_src;
      hi_src_e hi_src;
      logic    illegal;
   } route_t;

endpackage

// File: rtl/bus_rdsrc_decode.sv
module bus_rdsrc_decode
   import bus_rdsrc_pkg::*;
(
   input  logic   sel_stat_i,
   input  logic   sel_ctrl_i,
   input  logic   sel_half_i,
   output route_t route_o
);

   logic [1:0] n_high;

   always_comb begin
      n_high = {1'b0, sel_stat_i} + {1'b0, sel_ctrl_i} + {1'b0, sel_half_i};
      route_o.illegal = (n_high > 2'd1);
      if (sel_ctrl_i && sel_stat_i) begin
         route_o.lo_src = LO_IDLE;
      end else if (sel_ctrl_i) begin
         route_o.lo_src = LO_CTRL;
      end else if (sel_stat_i) begin
         route_o.lo_src = LO_STAT;
      end else begin
         route_o.lo_src = LO_DATA;
      end
      route_o.hi_src = (sel_stat_i | sel_ctrl_i | sel_half_i) ? HI_FILL : HI_DATA;
   end

endmodule

// File: rtl/bus_rdsrc_lo_lane.sv
module bus_rdsrc_lo_lane
   import bus_rdsrc_pkg::*;
#(
   parameter int LO_W   = 8,
   parameter int CTRL_W = 6,
   parameter int CST_W  = 4,
   parameter int FST_W  = 4
) (
   input  lo_src_e           src_i,
   input  logic [LO_W-1:0]   data_lo_ni,
   input  logic [CTRL_W-1:0] ctrl_ni,
   input  logic [CST_W-1:0]  cst_ni,
   input  logic [FST_W-1:0]  fst_ni,
   output logic [LO_W-1:0]   lane_no
);

   localparam int STAT_W = CST_W + FST_W;

   logic [LO_W-1:0] ctrl_word;
   logic [LO_W-1:0] stat_word;

   // Narrow sources, padded with the inactive level
   generate
      if (CTRL_W < LO_W) begin : g_ctrl_pad
         assign ctrl_word = {{(LO_W-CTRL_W){1'b1}}, ctrl_ni};
      end else begin : g_ctrl_full
         assign ctrl_word = ctrl_ni;
      end
      if (STAT_W < LO_W) begin : g_stat_pad
         assign stat_word = {{(LO_W-STAT_W){1'b1}}, fst_ni, cst_ni};
      end else begin : g_stat_full
         assign stat_word = {fst_ni, cst_ni};
      end
   endgenerate

   // Four-to-one choice, one per bit
   generate
      for (genvar b = 0; b < LO_W; b++) begin : g_bit
         always_comb begin
            unique case (src_i)
               LO_DATA: lane_no[b] = data_lo_ni[b];
               LO_STAT: lane_no[b] = stat_word[b];
               LO_CTRL: lane_no[b] = ctrl_word[b];
               default: lane_no[b] = 1'b1;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/bus_rdsrc_hi_lane.sv
module bus_rdsrc_hi_lane
   import bus_rdsrc_pkg::*;
#(
   parameter int HI_W = 8
) (
   input  hi_src_e         src_i,
   input  logic [HI_W-1:0] data_hi_ni,
   output logic [HI_W-1:0] lane_no
);

   generate
      for (genvar b = 0; b < HI_W; b++) begin : g_bit
         assign lane_no[b] = (src_i == HI_DATA) ? data_hi_ni[b] : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/bus_rdsrc_out.sv
module bus_rdsrc_out #(
   parameter int  DATA_W  = 16,
   parameter bit  REG_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_ni,
   input  logic              err_i,
   output logic [DATA_W-1:0] word_no,
   output logic              err_o
);

   generate
      if (REG_OUT) begin : g_reg
         logic [DATA_W-1:0] word_q;
         logic              err_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               word_q <= '1;
               err_q  <= 1'b0;
            end else if (load_i) begin
               word_q <= word_ni;
               err_q  <= err_i;
            end
         end
         assign word_no = word_q;
         assign err_o   = err_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk_i ^ rst_ni ^ load_i;
         assign word_no   = word_ni;
         assign err_o     = err_i;
      end
   endgenerate

endmodule

// File: rtl/bus_rdsrc_sel.sv
module bus_rdsrc_sel
   import bus_rdsrc_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CTRL_W  = 6,
   parameter int CST_W   = 4,
   parameter int FST_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              sel_stat_i,
   input  logic              sel_ctrl_i,
   input  logic              sel_half_i,
   input  logic [DATA_W-1:0] in_data_ni,
   input  logic [CTRL_W-1:0] ctrl_ni,
   input  logic [CST_W-1:0]  ctl_stat_ni,
   input  logic [FST_W-1:0]  fmt_stat_ni,
   output logic [DATA_W-1:0] rd_data_no,
   output logic              sel_err_o
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bus_rdsrc_sel: DATA_W must be at least 2");
      end
      if (CTRL_W > LO_W) begin : g_bad_ctrl
         $error("bus_rdsrc_sel: CTRL_W exceeds the lower lane");
      end
      if (CST_W + FST_W > LO_W) begin : g_bad_stat
         $error("bus_rdsrc_sel: status bits exceed the lower lane");
      end
   endgenerate

   route_t            route;
   logic [LO_W-1:0]   lo_lane_n;
   logic [HI_W-1:0]   hi_lane_n;
   logic [DATA_W-1:0] pick_n;

   bus_rdsrc_decode u_dec (
      .sel_stat_i (sel_stat_i),
      .sel_ctrl_i (sel_ctrl_i),
      .sel_half_i (sel_half_i),
      .route_o    (route)
   );

   bus_rdsrc_lo_lane #(
      .LO_W   (LO_W),
      .CTRL_W (CTRL_W),
      .CST_W  (CST_W),
      .FST_W  (FST_W)
   ) u_lo (
      .src_i      (route.lo_src),
      .data_lo_ni (in_data_ni[LO_W-1:0]),
      .ctrl_ni    (ctrl_ni),
      .cst_ni     (ctl_stat_ni),
      .fst_ni     (fmt_stat_ni),
      .lane_no    (lo_lane_n)
   );

   bus_rdsrc_hi_lane #(
      .HI_W (HI_W)
   ) u_hi (
      .src_i      (route.hi_src),
      .data_hi_ni (in_data_ni[DATA_W-1:LO_W]),
      .lane_no    (hi_lane_n)
   );

   // Illegal selects are forced to the all-inactive word
   assign pick_n = route.illegal ? '1 : {hi_lane_n, lo_lane_n};

   bus_rdsrc_out #(
      .DATA_W  (DATA_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .word_ni (pick_n),
      .err_i   (route.illegal),
      .word_no (rd_data_no),
      .err_o   (sel_err_o)
   );

endmodule

// File: rtl/bus_rdsrc_sel_chk.sv
module bus_rdsrc_sel_chk #(
   parameter int DATA_W  = 16,
   parameter int CTRL_W  = 6,
   parameter int CST_W   = 4,
   parameter int FST_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              load_i,
   input logic              sel_stat_i,
   input logic              sel_ctrl_i,
   input logic              sel_half_i,
   input logic [DATA_W-1:0] in_data_ni,
   input logic [CTRL_W-1:0] ctrl_ni,
   input logic [CST_W-1:0]  ctl_stat_ni,
   input logic [FST_W-1:0]  fmt_stat_ni,
   input logic [DATA_W-1:0] rd_data_no,
   input logic              sel_err_o
);

   localparam int LO_W   = DATA_W / 2;
   localparam int STAT_W = CST_W + FST_W;

   logic [2:0] sels;
   assign sels = {sel_half_i, sel_ctrl_i, sel_stat_i};

   generate
      if (REG_OUT) begin : g_props
         // R1
         data_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && sels == 3'b000) |=> rd_data_no == $past(in_data_ni));

         // R2
         ctrl_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && sels == 3'b010) |=>
               (rd_data_no[CTRL_W-1:0] == $past(ctrl_ni)) &&
               (&rd_data_no[DATA_W-1:CTRL_W]));

         // R3
         stat_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && sels == 3'b001) |=>
               (rd_data_no[STAT_W-1:0] == {$past(fmt_stat_ni), $past(ctl_stat_ni)}) &&
               (&rd_data_no[DATA_W-1:STAT_W]));

         // R4
         half_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && sels == 3'b100) |=>
               (rd_data_no[LO_W-1:0] == $past(in_data_ni[LO_W-1:0])) &&
               (&rd_data_no[DATA_W-1:LO_W]));

         // R6
         illegal_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && $countones(sels) > 1) |=> (&rd_data_no) && sel_err_o);

         // R7
         err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_i && $countones(sels) <= 1) |=> !sel_err_o);

         // R8
         hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !load_i |=> $stable(rd_data_no) && $stable(sel_err_o));
      end
   endgenerate

endmodule

bind bus_rdsrc_sel bus_rdsrc_sel_chk #(
   .DATA_W  (DATA_W),
   .CTRL_W  (CTRL_W),
   .CST_W   (CST_W),
   .FST_W   (FST_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .load_i      (load_i),
   .sel_stat_i  (sel_stat_i),
   .sel_ctrl_i  (sel_ctrl_i),
   .sel_half_i  (sel_half_i),
   .in_data_ni  (in_data_ni),
   .ctrl_ni     (ctrl_ni),
   .ctl_stat_ni (ctl_stat_ni),
   .fmt_stat_ni (fmt_stat_ni),
   .rd_data_no  (rd_data_no),
   .sel_err_o   (sel_err_o)
);

// File: tb/bus_rdsrc_sel_test.sv
module bus_rdsrc_sel_test;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [15:0] word;
      logic        err;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        s_stat = 1'b0;
   logic        s_ctrl = 1'b0;
   logic        s_half = 1'b0;
   logic [15:0] din = 16'h0000;
   logic [5:0]  ctrl = 6'h00;
   logic [3:0]  cst = 4'h0;
   logic [3:0]  fst = 4'h0;
   logic [15:0] dout;
   logic        err;

   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_rdsrc_sel uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .load_i      (load),
      .sel_stat_i  (s_stat),
      .sel_ctrl_i  (s_ctrl),
      .sel_half_i  (s_half),
      .in_data_ni  (din),
      .ctrl_ni     (ctrl),
      .ctl_stat_ni (cst),
      .fmt_stat_ni (fst),
      .rd_data_no  (dout),
      .sel_err_o   (err)
   );

   // Reference built from the requirements
   function automatic exp_t model(input logic [2:0] s, input string req);
      exp_t e;
      e.req = req;
      e.err = 1'b0;
      case (s)
         3'b000:  e.word = din;                          // R1
         3'b010:  e.word = {10'h3FF, ctrl};              // R2
         3'b001:  e.word = {8'hFF, fst, cst};            // R3
         3'b100:  e.word = {8'hFF, din[7:0]};            // R4
         default: begin e.word = 16'hFFFF; e.err = 1'b1; end  // R6
      endcase
      return e;
   endfunction

   task automatic check(input string req, input logic [15:0] w_exp, input logic e_exp);
      n_run++;
      if (dout !== w_exp || err !== e_exp) begin
         n_fail++;
         $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                  req, dout, err, w_exp, e_exp);
      end
   endtask

   // Driver: one load per call, expected result pushed to the scoreboard
   task automatic drive(input logic [2:0] s, input logic [15:0] d, input logic [5:0] c,
                        input logic [3:0] cs, input logic [3:0] fs, input string req);
      @(negedge clk);
      {s_half, s_ctrl, s_stat} = s;
      din = d; ctrl = c; cst = cs; fst = fs;
      load = 1'b1;
      sb.push_back(model(s, req));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         load = 1'b0;
      end
   endtask

   // Monitor: pop after each captured load
   initial begin
      forever begin
         @(posedge clk);
         if (load && rst_n) begin
            @(negedge clk);
            if (sb.size() == 0) begin
               n_run++; n_fail++;
               $display("FAIL scoreboard: empty queue at load, data=%h expected none", dout);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.req, e.word, e.err);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not finish, queue=%0d expected 0", sb.size());
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      din = 16'h5A5A; s_stat = 1'b1; s_ctrl = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 reset", 16'hFFFF, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 after release", 16'hFFFF, 1'b0);

      drive(3'b000, 16'hA5C3, 6'h2A, 4'h3, 4'hC, "R1 data");
      drive(3'b000, 16'h0001, 6'h00, 4'h0, 4'h0, "R1 data walk");
      drive(3'b000, 16'h8000, 6'h3F, 4'hF, 4'hF, "R1 data msb");
      drive(3'b010, 16'h0000, 6'h15, 4'h0, 4'h0, "R2 ctrl");
      drive(3'b010, 16'h1234, 6'h2A, 4'h5, 4'h9, "R2 ctrl alt");
      drive(3'b001, 16'h0000, 6'h00, 4'hA, 4'h6, "R3 status");
      drive(3'b001, 16'hFFFF, 6'h3F, 4'h1, 4'h8, "R3 status order");
      drive(3'b100, 16'h1234, 6'h00, 4'h0, 4'h0, "R4 half");
      drive(3'b100, 16'h00C7, 6'h11, 4'h2, 4'h2, "R4 half alt");
      drive(3'b011, 16'h0000, 6'h00, 4'h0, 4'h0, "R6 stat+ctrl");
      drive(3'b000, 16'h0F0F, 6'h00, 4'h0, 4'h0, "R7 clear after illegal");
      drive(3'b101, 16'h0000, 6'h00, 4'h0, 4'h0, "R6 stat+half");
      idle(1);

      // R8: inputs move with load low, prior illegal result must stay
      @(negedge clk);
      {s_half, s_ctrl, s_stat} = 3'b000; din = 16'h0000; ctrl = 6'h00;
      @(negedge clk);
      check("R8 hold after illegal", 16'hFFFF, 1'b1);
      {s_half, s_ctrl, s_stat} = 3'b010; din = 16'h3C3C;
      @(negedge clk);
      check("R8 hold with new strobes", 16'hFFFF, 1'b1);

      drive(3'b110, 16'h1111, 6'h01, 4'h1, 4'h1, "R6 ctrl+half");
      drive(3'b111, 16'h2222, 6'h02, 4'h2, 4'h2, "R6 all three");
      drive(3'b001, 16'h0000, 6'h00, 4'h7, 4'hE, "R7 clear via status");
      idle(1);
      @(negedge clk);
      din = 16'hDEAD; {s_half, s_ctrl, s_stat} = 3'b000;
      @(negedge clk);
      check("R8 hold legal", 16'hFFE7, 1'b0);
      idle(2);

      if (sb.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule